// File: doc/BRIEF.md
# Strobed Three-Wire Display Bus Master

This block drives a display-and-keypad controller that sits on a three-line serial bus: a strobe line that frames each transaction, a clock line, and one shared data line. A host starts a transaction with a single-cycle start pulse. In write mode the block shifts out a command byte and then any number of further bytes, which the host feeds one at a time through a byte port with a last flag. In read mode the block sends the key-scan read command, releases the data line, and clocks in between one and four bytes. It packs them into a 32-bit result.

All bus timing comes from one programmable delay count, in system clock cycles, that sets the length of every bus phase. The bus has no acknowledge. The block only moves bytes: it does not format display content and it does not decode keys.

Top module: `strobe_disp_master`

## Requirements
- R1: After an accepted start, strobe stays high for one delay period and then goes low. Clock and data lines stay high for one more delay period before the first clock fall.
- R2: Write bits leave least significant bit first. Each bit has three phases of one delay period each: clock low, then data set, then clock high. Data does not change while the clock is high inside a frame.
- R3: Bytes after the first come from the host byte port. `tx_take_o` pulses once for every byte the block latches. The byte that was latched with `tx_last_i` high is the final byte of the frame.
- R4: After the last bit, the block waits one delay period and then returns strobe, clock and data to high in the same cycle, with the data driver enabled. `done_o` pulses for one cycle in that same cycle.
- R5: A read first sends command byte 0x42 with its bits in the same order as R2. It then drops `dio_oe_o` to release the data line and waits at least one delay period before the first read clock fall. The data line stays released only while strobe is low.
- R6: Each read bit is clocked by driving the clock low, waiting one delay period, then raising it, and sampling `dio_i` at the end of the clock-high phase. The first bit of each byte lands in bit 7. Read byte k lands in `result_o[8k+7:8k]`.
- R7: A read request whose count is 0 or greater than 4 is rejected. `done_o` and `err_o` pulse together in the cycle after the start, with no clock or strobe activity, `busy_o` stays low, and `result_o` keeps its previous value.
- R8: At the start of a valid read, `result_o` is cleared, so byte positions at or beyond the requested count read as zero.
- R9: A delay count of zero gives the same timing as a count of one.
- R10: `busy_o` is high from the cycle after an accepted start until the cycle in which `done_o` pulses. Strobe is high whenever `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle start request, sampled while idle |
| rd_i | input | 1 | 1 = key-scan read, 0 = write |
| rd_cnt_i | input | 3 | Number of bytes to read, valid range 1..4 |
| delay_i | input | 8 | Clock cycles per bus phase (0 acts as 1) |
| tx_byte_i | input | 8 | Next byte to send |
| tx_last_i | input | 1 | Marks tx_byte_i as the final byte |
| tx_take_o | output | 1 | Pulses when tx_byte_i has been latched |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transaction or a rejection |
| err_o | output | 1 | One-cycle pulse, together with done_o, on a rejected read count |
| result_o | output | 32 | Read bytes; byte k in bits 8k+7..8k |
| stb_o | output | 1 | Strobe line, low frames a transaction |
| sclk_o | output | 1 | Bus clock line |
| dio_o | output | 1 | Data line output value |
| dio_oe_o | output | 1 | Data line driver enable (0 = released) |
| dio_i | input | 1 | Data line input value |

## Verification
The checker assumes that `start_i` is raised only while `busy_o` is low. It also assumes that the device on the far side changes `dio_i` only after a clock fall. The bench's bus model meets the second assumption by updating `dio_i` on every clock fall while the data line is released. Its host tasks meet the first by pulsing start only after the previous `done_o`. For every byte the block latches, the host tasks present the next byte right after the take pulse, which gives the block the whole of the following bit phases to use it.

// File: rtl/sdm_pkg.sv
// Package: shared state encoding and constants for the strobed display master.
// Assumes: nothing beyond a SystemVerilog 2017 compiler.
package sdm_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,   // bus idle, all lines high
        ST_LEAD,   // delay before strobe falls
        ST_FRAME,  // strobe low, delay before first clock
        ST_WLO,    // write bit: clock low
        ST_WDAT,   // write bit: data driven
        ST_WHI,    // write bit: clock high
        ST_TURN,   // data line released, turnaround wait
        ST_RLO,    // read bit: clock low
        ST_RHI,    // read bit: clock high, sample at end
        ST_TAIL    // delay before releasing the frame
    } sdm_state_t;

    localparam logic [7:0] SDM_READ_CMD = 8'h42;
endpackage

// File: rtl/sdm_phase_timer.sv
// Module: down-counter that times one bus phase.
// Loading with period P makes zero_o rise after max(P,1) cycles.
// Assumes: load_i is asserted on the cycle a phase begins.
module sdm_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] period_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] eff;

    // Clamp a zero period to one cycle.
    always_comb eff = (period_i == '0) ? W'(1) : period_i;

    // Reload on phase start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= eff - W'(1);
        else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdm_rx_collect.sv
// Module: assembles read bits into the packed result word.
// The first bit of each byte goes to the byte's bit 7.
// Assumes: byte_i < NB whenever smp_i is high.
module sdm_rx_collect #(
    parameter int NB    = 4,
    parameter int IDX_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            smp_i,
    input  logic [IDX_W-1:0] byte_i,
    input  logic [2:0]      bit_i,
    input  logic            din_i,
    output logic [8*NB-1:0] data_o
);
    // Clear at the start of a read, then store each sampled bit in place.
    always_ff @(posedge clk) begin
        if (!rst_n)     data_o <= '0;
        else if (clr_i) data_o <= '0;
        else if (smp_i) data_o[int'(byte_i) * 8 + (7 - int'(bit_i))] <= din_i;
    end
endmodule

// File: rtl/strobe_disp_master.sv
// Module: three-wire strobed bus master for a display/keypad controller.
// Sends a byte stream (write) or the read command followed by 1..NB read bytes.
// Assumes: start_i only while busy_o is low; the far side changes dio_i after a clock fall.
module strobe_disp_master
    import sdm_pkg::*;
#(
    parameter int DLY_W = 8,
    parameter int NB    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rd_i,
    input  logic [2:0]       rd_cnt_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic [7:0]       tx_byte_i,
    input  logic             tx_last_i,
    output logic             tx_take_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [8*NB-1:0]  result_o,
    output logic             stb_o,
    output logic             sclk_o,
    output logic             dio_o,
    output logic             dio_oe_o,
    input  logic             dio_i
);
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;

    sdm_state_t       state_q;
    logic [DLY_W-1:0] dly_q;
    logic [7:0]       sh_q;
    logic [2:0]       bit_q;
    logic [IDX_W-1:0] byte_q;
    logic [IDX_W-1:0] last_idx_q;
    logic             rd_q;
    logic             last_q;
    logic             bad_cnt;
    logic             accept;
    logic             tmr_load;
    logic             tmr_zero;
    logic [DLY_W-1:0] period;

    // Decide whether a start request is legal.
    always_comb begin
        bad_cnt = rd_i && ((rd_cnt_i == 3'd0) || (int'(rd_cnt_i) > NB));
        accept  = (state_q == ST_IDLE) && start_i && !bad_cnt;
    end

    // Reload the phase timer at each phase boundary.
    always_comb begin
        period   = (state_q == ST_IDLE) ? delay_i : dly_q;
        tmr_load = accept || ((state_q != ST_IDLE) && tmr_zero);
    end

    sdm_phase_timer #(.W(DLY_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .period_i (period),
        .zero_o   (tmr_zero)
    );

    sdm_rx_collect #(.NB(NB), .IDX_W(IDX_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (accept && rd_i),
        .smp_i  ((state_q == ST_RHI) && tmr_zero),
        .byte_i (byte_q),
        .bit_i  (bit_q),
        .din_i  (dio_i),
        .data_o (result_o)
    );

    // Phase sequencer and registered bus lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            dly_q      <= '0;
            sh_q       <= '0;
            bit_q      <= '0;
            byte_q     <= '0;
            last_idx_q <= '0;
            rd_q       <= 1'b0;
            last_q     <= 1'b0;
            tx_take_o  <= 1'b0;
            busy_o     <= 1'b0;
            done_o     <= 1'b0;
            err_o      <= 1'b0;
            stb_o      <= 1'b1;
            sclk_o     <= 1'b1;
            dio_o      <= 1'b1;
            dio_oe_o   <= 1'b1;
        end else begin
            tx_take_o <= 1'b0;
            done_o    <= 1'b0;
            err_o     <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i && bad_cnt) begin
                        done_o <= 1'b1;
                        err_o  <= 1'b1;
                    end else if (accept) begin
                        state_q    <= ST_LEAD;
                        busy_o     <= 1'b1;
                        dly_q      <= delay_i;
                        rd_q       <= rd_i;
                        bit_q      <= '0;
                        byte_q     <= '0;
                        last_idx_q <= IDX_W'(rd_cnt_i - 3'd1);
                        if (rd_i) begin
                            sh_q   <= SDM_READ_CMD;
                            last_q <= 1'b1;
                        end else begin
                            sh_q      <= tx_byte_i;
                            last_q    <= tx_last_i;
                            tx_take_o <= 1'b1;
                        end
                    end
                end
                ST_LEAD: if (tmr_zero) begin
                    state_q <= ST_FRAME;
                    stb_o   <= 1'b0;
                end
                ST_FRAME: if (tmr_zero) begin
                    state_q <= ST_WLO;
                    sclk_o  <= 1'b0;
                end
                ST_WLO: if (tmr_zero) begin
                    state_q <= ST_WDAT;
                    dio_o   <= sh_q[0];
                end
                ST_WDAT: if (tmr_zero) begin
                    state_q <= ST_WHI;
                    sclk_o  <= 1'b1;
                end
                ST_WHI: if (tmr_zero) begin
                    sh_q  <= {1'b0, sh_q[7:1]};
                    bit_q <= bit_q + 3'd1;
                    if (bit_q != 3'd7) begin
                        state_q <= ST_WLO;
                        sclk_o  <= 1'b0;
                    end else if (rd_q) begin
                        state_q  <= ST_TURN;
                        dio_oe_o <= 1'b0;
                    end else if (last_q) begin
                        state_q <= ST_TAIL;
                    end else begin
                        state_q   <= ST_WLO;
                        sclk_o    <= 1'b0;
                        sh_q      <= tx_byte_i;
                        last_q    <= tx_last_i;
                        tx_take_o <= 1'b1;
                    end
                end
                ST_TURN: if (tmr_zero) begin
                    state_q <= ST_RLO;
                    sclk_o  <= 1'b0;
                end
                ST_RLO: if (tmr_zero) begin
                    state_q <= ST_RHI;
                    sclk_o  <= 1'b1;
                end
                ST_RHI: if (tmr_zero) begin
                    bit_q <= bit_q + 3'd1;
                    if (bit_q != 3'd7) begin
                        state_q <= ST_RLO;
                        sclk_o  <= 1'b0;
                    end else if (byte_q == last_idx_q) begin
                        state_q <= ST_TAIL;
                    end else begin
                        byte_q  <= byte_q + IDX_W'(1);
                        state_q <= ST_RLO;
                        sclk_o  <= 1'b0;
                    end
                end
                ST_TAIL: if (tmr_zero) begin
                    state_q  <= ST_IDLE;
                    busy_o   <= 1'b0;
                    done_o   <= 1'b1;
                    stb_o    <= 1'b1;
                    sclk_o   <= 1'b1;
                    dio_o    <= 1'b1;
                    dio_oe_o <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdm_checker.sv
// Module: protocol checker for strobe_disp_master, attached by bind.
// Assumes: observes only the top-level ports.
module sdm_checker (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic done_o,
    input logic err_o,
    input logic stb_o,
    input logic sclk_o,
    input logic dio_o,
    input logic dio_oe_o
);
    // R10: strobe is high whenever no transaction runs.
    assert_idle_stb_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> stb_o);

    // R5: the data line is released only inside a strobe frame.
    assert_release_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !dio_oe_o |-> !stb_o);

    // R2: written data holds while the clock is high inside a frame.
    assert_data_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o) && !stb_o && $past(!stb_o) && dio_oe_o && $past(dio_oe_o))
        |-> $stable(dio_o));

    // R4: done is a single-cycle pulse and comes with all lines high.
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_lines_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (stb_o && sclk_o && dio_o && dio_oe_o && !busy_o));

    // R7: an error always comes with done.
    assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    // R1: the clock line only goes low inside a strobe frame.
    assert_clk_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_o |-> !stb_o);
endmodule

bind strobe_disp_master sdm_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .stb_o    (stb_o),
    .sclk_o   (sclk_o),
    .dio_o    (dio_o),
    .dio_oe_o (dio_oe_o)
);

// File: tb/sim_strobe_disp_master.sv
module sim_strobe_disp_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [2:0]  rd_cnt_i = 3'd0;
    logic [7:0]  delay_i = 8'd1;
    logic [7:0]  tx_byte_i = 8'h00;
    logic        tx_last_i = 1'b0;
    logic        tx_take_o, busy_o, done_o, err_o;
    logic [31:0] result_o;
    logic        stb_o, sclk_o, dio_o, dio_oe_o;
    logic        dio_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    int takes = 0;
    int cap_bits = 0;
    int rb = 0;
    int nfall = 0;
    logic [7:0]  cap [8];
    logic [31:0] resp = 32'h0;

    always #5 clk = ~clk;

    strobe_disp_master u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i), .rd_cnt_i(rd_cnt_i),
        .delay_i(delay_i), .tx_byte_i(tx_byte_i), .tx_last_i(tx_last_i), .tx_take_o(tx_take_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .result_o(result_o),
        .stb_o(stb_o), .sclk_o(sclk_o), .dio_o(dio_o), .dio_oe_o(dio_oe_o), .dio_i(dio_i)
    );

    // Bus model: capture driven bits on clock rise, supply read bits on clock fall.
    always @(negedge stb_o) begin cap_bits = 0; rb = 0; end
    always @(posedge stb_o) dio_i = 1'b1;
    always @(posedge sclk_o) begin
        if (stb_o === 1'b0 && dio_oe_o === 1'b1 && cap_bits < 64) begin
            cap[cap_bits / 8][cap_bits % 8] = dio_o;
            cap_bits++;
        end
    end
    always @(negedge sclk_o) begin
        nfall++;
        if (stb_o === 1'b0 && dio_oe_o === 1'b0 && rb < 32) begin
            dio_i = resp[(rb / 8) * 8 + 7 - (rb % 8)];
            rb++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Vector: [43] rd, [42:40] read count, [39:36] delay, [35:32] byte count, [31:0] data.
    localparam logic [43:0] VEC [6] = '{
        {1'b0, 3'd0, 4'd1, 4'd1, 32'h000000A5},
        {1'b0, 3'd0, 4'd2, 4'd3, 32'h0039FF01},
        {1'b0, 3'd0, 4'd0, 4'd4, 32'h80402010},
        {1'b1, 3'd1, 4'd1, 4'd0, 32'h123456C3},
        {1'b1, 3'd4, 4'd2, 4'd0, 32'hDEADBEEF},
        {1'b1, 3'd3, 4'd0, 4'd0, 32'h7F813C5A}
    };

    task automatic run(input bit rd, input logic [2:0] cnt, input logic [7:0] dly,
                       input int nb, input logic [31:0] data);
        int idx;
        int guard;
        takes = 0;
        resp  = data;
        @(negedge clk);
        rd_i = rd; rd_cnt_i = cnt; delay_i = dly;
        tx_byte_i = data[7:0]; tx_last_i = (nb == 1); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        idx = 1;
        guard = 0;
        while (!done_o && guard < 20000) begin
            if (tx_take_o) begin
                takes++;
                if (idx < 4) begin
                    tx_byte_i = data[idx * 8 +: 8];
                    tx_last_i = (idx == nb - 1);
                end
                idx++;
            end
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] exp;
        int n;
        repeat (3) @(negedge clk);
        // Reset state.
        check("R10 reset busy", {31'b0, busy_o}, 32'h0);
        check("R4 reset lines", {28'b0, stb_o, sclk_o, dio_o, dio_oe_o}, 32'hF);
        check("R8 reset result", result_o, 32'h0);
        rst_n = 1'b1;

        // Table walk.
        for (int v = 0; v < 6; v++) begin
            run(VEC[v][43], VEC[v][42:40], {4'b0, VEC[v][39:36]}, int'(VEC[v][35:32]), VEC[v][31:0]);
            check("R4 done reached", {31'b0, done_o}, 32'h1);
            if (!VEC[v][43]) begin
                check("R2 write bit count", cap_bits, VEC[v][35:32] * 8);
                for (int k = 0; k < int'(VEC[v][35:32]); k++)
                    check("R2 write byte LSB first", {24'b0, cap[k]}, {24'b0, VEC[v][k*8 +: 8]});
                check("R3 take pulses", takes, VEC[v][35:32]);
            end else begin
                check("R5 read command", {24'b0, cap[0]}, 32'h42);
                check("R5 only command driven", cap_bits, 8);
                exp = 32'h0;
                for (int k = 0; k < int'(VEC[v][42:40]); k++) exp[k*8 +: 8] = VEC[v][k*8 +: 8];
                check("R6 R8 read result", result_o, exp);
            end
            @(negedge clk);
            check("R4 idle lines", {28'b0, stb_o, sclk_o, dio_o, dio_oe_o}, 32'hF);
        end

        // R7: invalid counts leave the bus untouched and keep the result.
        for (int c = 0; c < 8; c += 5) begin
            n = nfall;
            exp = result_o;
            @(negedge clk);
            rd_i = 1'b1; rd_cnt_i = 3'(c); start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            check("R7 err pulse", {30'b0, done_o, err_o}, 32'h3);
            check("R7 busy low", {31'b0, busy_o}, 32'h0);
            repeat (5) @(negedge clk);
            check("R7 no clock", nfall - n, 0);
            check("R7 strobe high", {31'b0, stb_o}, 32'h1);
            check("R7 result kept", result_o, exp);
        end

        // R1 R9: strobe lead timing for delays 3, 0 and 1.
        for (int d = 0; d < 3; d++) begin
            logic [7:0] dl;
            int eff;
            dl  = (d == 0) ? 8'd3 : ((d == 1) ? 8'd0 : 8'd1);
            eff = (dl == 0) ? 1 : int'(dl);
            @(negedge clk);
            rd_i = 1'b0; delay_i = dl; tx_byte_i = 8'h3C; tx_last_i = 1'b1; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            check("R10 busy after start", {31'b0, busy_o}, 32'h1);
            n = 0;
            while (stb_o && n < 100) begin n++; @(negedge clk); end
            check((d == 1) ? "R9 zero delay lead" : "R1 strobe lead", n, eff);
            n = 0;
            while (sclk_o && n < 100) begin n++; @(negedge clk); end
            check("R1 clock lead", n, eff);
            n = 0;
            while (!done_o && n < 5000) begin n++; @(negedge clk); end
            check("R2 byte sent", {24'b0, cap[0]}, 32'h3C);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule